// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block answers a load lookup for a core that uses 4 KB pages. It combines an address translation buffer with a two-way set-associative data cache. The set index and the position inside the line are taken only from the low 12 address bits, which translation leaves unchanged. The cache set can therefore be read in the same cycle that the translation buffer is searched. The physical page number that the buffer returns is then compared against the stored tag of each way. That comparison decides hit or miss and selects the word that is returned.

The translation buffer is fully associative and holds 8 entries. It is loaded from outside through a refill port, and the slot to write is chosen round-robin. Cache lines are loaded through a second refill port that takes a physical address and a 16-byte line. Each set keeps one bit that records which way was used less recently. Walking the page table and fetching from memory are left to the logic around this block. On a translation miss the block only reports the miss.

Top module: `vipt_lookup`

## Requirements
- R1: A lookup presented with `req_valid_i` high at one rising edge produces its response registered at that edge, so `resp_valid_o` is high for exactly that following cycle. `resp_valid_o` is low in any cycle that follows an edge with no request, and it is low after reset.
- R2: The translation buffer compares virtual page number `req_vaddr_i[31:12]` against all valid entries in the same cycle. A matching entry supplies the physical page number. When no entry matches, the response has `resp_tlb_miss_o`=1, `resp_hit_o`=0 and `resp_data_o`=0. Software installs no two entries with the same virtual page.
- R3: The set index is `req_vaddr_i[11:4]` (256 sets). Both ways of that set are checked, and a way hits only if it is valid and its 20-bit tag equals the translated physical page number.
- R4: On a hit, `resp_data_o` is the 32-bit word of the hitting line selected by `req_vaddr_i[3:2]`. Word 0 is line bits [31:0], and bits [1:0] of the address do not affect the result. On a cache miss with a valid translation, `resp_hit_o`=0, `resp_tlb_miss_o`=0 and `resp_data_o`=0.
- R5: A translation miss forces `resp_hit_o` to 0 even when a stored tag equals the page number driven by the empty translation result (zero).
- R6: A line fill writes tag `line_fill_paddr_i[31:12]` into set `line_fill_paddr_i[11:4]`. The way written is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way that the set's recency bit marks as less recently used.
- R7: The recency bit of a set is set to point at the other way after every hit in that set and after every fill into that set.
- R8: Translation refills go to entries 0, 1, …, 7 in order and then wrap to entry 0, replacing whatever that entry holds. Reset invalidates every translation entry and every cache line.
- R9: Two virtual pages that translate to the same physical page hit the same cache line, and at equal page offsets they return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address of the lookup |
| resp_valid_o | output | 1 | Response valid, one cycle after the request |
| resp_hit_o | output | 1 | Translated and found in the cache |
| resp_tlb_miss_o | output | 1 | No translation for the page |
| resp_data_o | output | 32 | Selected word on a hit, otherwise zero |
| tlb_fill_i | input | 1 | Write a translation entry |
| tlb_fill_vpn_i | input | 20 | Virtual page number to install |
| tlb_fill_ppn_i | input | 20 | Physical page number to install |
| line_fill_i | input | 1 | Write a cache line |
| line_fill_paddr_i | input | 32 | Physical address of the line |
| line_fill_data_i | input | 128 | Line contents, word 0 in bits [31:0] |

## Verification
Every response is due exactly one clock edge after its request. The bench therefore drives each lookup at a falling edge, lets one rising edge pass, and reads all four response outputs at the next falling edge. It then confirms that `resp_valid_o` has dropped one cycle later when no request follows. Fills of either kind take effect at the edge that samples them. For that reason every fill occupies a full cycle before the lookup that depends on it. Expected words are computed arithmetically from the physical page, set and word number, so the sweep over sets, words and byte offsets has no stored answer table.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int PAGE_OFF_W = 12;
  localparam int WAYS       = 2;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = valid_q[e] && (vpn_q[e] == lookup_vpn_i);
  end

  assign hit_o = |match;

  always_comb begin
    ppn_o = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (match[e]) ppn_o = ppn_o | ppn_q[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      vpn_q[ptr_q] <= fill_vpn_i;
      ppn_q[ptr_q] <= fill_ppn_i;
    end
  end

  // R2: at most one entry may claim a page
  p_single_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/vipt_cache_array.sv
module vipt_cache_array #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output logic [1:0]             rd_valid_o,
  output logic [1:0][TAG_W-1:0]  rd_tag_o,
  output logic [1:0][LINE_W-1:0] rd_line_o,
  input  logic                   touch_i,
  input  logic                   touch_way_i,
  input  logic                   fill_i,
  input  logic [IDX_W-1:0]       fill_idx_i,
  input  logic [TAG_W-1:0]       fill_tag_i,
  input  logic [LINE_W-1:0]      fill_line_i
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q [2];
  logic [SETS-1:0]   lru_q;
  logic [TAG_W-1:0]  tag_q  [2][SETS];
  logic [LINE_W-1:0] line_q [2][SETS];
  logic              victim;

  always_comb begin
    if (!valid_q[0][fill_idx_i])      victim = 1'b0;
    else if (!valid_q[1][fill_idx_i]) victim = 1'b1;
    else                              victim = lru_q[fill_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q[0] <= '0;
      valid_q[1] <= '0;
      lru_q      <= '0;
    end else begin
      if (touch_i) lru_q[rd_idx_i] <= ~touch_way_i;
      if (fill_i) begin
        valid_q[victim][fill_idx_i] <= 1'b1;
        lru_q[fill_idx_i]           <= ~victim;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[victim][fill_idx_i]  <= fill_tag_i;
      line_q[victim][fill_idx_i] <= fill_line_i;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rd_valid_o[w] = valid_q[w][rd_idx_i];
    assign rd_tag_o[w]   = tag_q[w][rd_idx_i];
    assign rd_line_o[w]  = line_q[w][rd_idx_i];
  end

  // R7: a hit leaves the recency bit naming the other way
  p_lru_touch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i && !fill_i |=> lru_q[$past(rd_idx_i)] == !$past(touch_way_i));
  // R6: way 0 is always occupied after a fill into its set
  p_fill_way0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[0][$past(fill_idx_i)]);
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int TLB_ENTRIES = 8,
  parameter int LINE_BYTES  = 16,
  parameter int WORD_W      = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [VA_W-1:0]           req_vaddr_i,
  output logic                      resp_valid_o,
  output logic                      resp_hit_o,
  output logic                      resp_tlb_miss_o,
  output logic [WORD_W-1:0]         resp_data_o,
  input  logic                      tlb_fill_i,
  input  logic [VA_W-PAGE_OFF_W-1:0] tlb_fill_vpn_i,
  input  logic [PA_W-PAGE_OFF_W-1:0] tlb_fill_ppn_i,
  input  logic                      line_fill_i,
  input  logic [PA_W-1:0]           line_fill_paddr_i,
  input  logic [LINE_BYTES*8-1:0]   line_fill_data_i
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = PAGE_OFF_W - OFF_W;  // index + offset fills the page offset
  localparam int VPN_W  = VA_W - PAGE_OFF_W;
  localparam int PPN_W  = PA_W - PAGE_OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WSEL_W = $clog2(LINE_W / WORD_W);
  localparam int BSEL_W = OFF_W - WSEL_W;

  logic              tlb_hit;
  logic [PPN_W-1:0]  ppn;
  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic [1:0]              rd_valid, way_hit;
  logic [1:0][PPN_W-1:0]   rd_tag;
  logic [1:0][LINE_W-1:0]  rd_line;
  logic [LINE_W-1:0] sel_line;
  logic [WORD_W-1:0] sel_word;
  logic              hit;

  assign idx  = req_vaddr_i[PAGE_OFF_W-1:OFF_W];
  assign wsel = req_vaddr_i[OFF_W-1:BSEL_W];

  vipt_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk_i, .rst_ni,
    .lookup_vpn_i (req_vaddr_i[VA_W-1:PAGE_OFF_W]),
    .hit_o        (tlb_hit),
    .ppn_o        (ppn),
    .fill_i       (tlb_fill_i),
    .fill_vpn_i   (tlb_fill_vpn_i),
    .fill_ppn_i   (tlb_fill_ppn_i)
  );

  vipt_cache_array #(.IDX_W(IDX_W), .TAG_W(PPN_W), .LINE_W(LINE_W)) u_array (
    .clk_i, .rst_ni,
    .rd_idx_i    (idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_line_o   (rd_line),
    .touch_i     (req_valid_i && hit),
    .touch_way_i (way_hit[1]),
    .fill_i      (line_fill_i),
    .fill_idx_i  (line_fill_paddr_i[PAGE_OFF_W-1:OFF_W]),
    .fill_tag_i  (line_fill_paddr_i[PA_W-1:PAGE_OFF_W]),
    .fill_line_i (line_fill_data_i)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = tlb_hit && rd_valid[w] && (rd_tag[w] == ppn);
  end

  assign hit      = |way_hit;
  assign sel_line = way_hit[1] ? rd_line[1] : rd_line[0];
  assign sel_word = sel_line[wsel*WORD_W +: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o    <= 1'b0;
      resp_hit_o      <= 1'b0;
      resp_tlb_miss_o <= 1'b0;
      resp_data_o     <= '0;
    end else begin
      resp_valid_o    <= req_valid_i;
      resp_hit_o      <= req_valid_i && hit;
      resp_tlb_miss_o <= req_valid_i && !tlb_hit;
      resp_data_o     <= (req_valid_i && hit) ? sel_word : '0;
    end
  end

  // R1: response exactly one cycle after a request
  p_resp_due_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  p_resp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);
  // R5: a missing translation never reports a hit
  p_miss_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_tlb_miss_o |-> resp_valid_o && !resp_hit_o);
  // R3: a physical line lives in at most one way of its set
  p_way_unique_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit));
endmodule

// File: tb/vipt_lookup_bench.sv
module vipt_lookup_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_vaddr = '0;
  logic         resp_valid, resp_hit, resp_tlb_miss;
  logic [31:0]  resp_data;
  logic         tlb_fill = 1'b0;
  logic [19:0]  tlb_vpn = '0, tlb_ppn = '0;
  logic         line_fill = 1'b0;
  logic [31:0]  line_paddr = '0;
  logic [127:0] line_data = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vipt_lookup u_vipt_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_tlb_miss_o(resp_tlb_miss), .resp_data_o(resp_data),
    .tlb_fill_i(tlb_fill), .tlb_fill_vpn_i(tlb_vpn), .tlb_fill_ppn_i(tlb_ppn),
    .line_fill_i(line_fill), .line_fill_paddr_i(line_paddr),
    .line_fill_data_i(line_data)
  );

  function automatic logic [31:0] word_of(logic [19:0] ppn, logic [7:0] idx, int w);
    return {ppn[11:0], idx, 8'(w), 4'h5};
  endfunction

  function automatic logic [127:0] line_of(logic [19:0] ppn, logic [7:0] idx);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of(ppn, idx, w);
    return l;
  endfunction

  function automatic logic [19:0] vpn_k(int k);
    return 20'h00100 + 20'(k * 3);
  endfunction

  function automatic logic [19:0] ppn_k(int k);
    return 20'h00A00 + 20'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_tlb(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    tlb_fill = 1'b1; tlb_vpn = v; tlb_ppn = p;
    @(negedge clk);
    tlb_fill = 1'b0;
  endtask

  task automatic fill_line(input logic [19:0] p, input logic [7:0] idx);
    @(negedge clk);
    line_fill = 1'b1; line_paddr = {p, idx, 4'h0}; line_data = line_of(p, idx);
    @(negedge clk);
    line_fill = 1'b0;
  endtask

  // drive at a falling edge, response registered at the next rising edge
  task automatic look(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input logic [31:0] exp);
    look(va);
    chk(resp_valid && resp_hit && !resp_tlb_miss, {req, " hit"}, {29'd0, resp_valid, resp_hit, resp_tlb_miss}, 32'd6);
    chk(resp_data == exp, {req, " data"}, resp_data, exp);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] va, input bit tlbm);
    look(va);
    chk(resp_valid && !resp_hit && resp_tlb_miss == tlbm && resp_data == 32'd0,
        req, {28'd0, resp_valid, resp_hit, resp_tlb_miss, 1'b0} ^ resp_data,
        {28'd0, 1'b1, 1'b0, tlbm, 1'b0});
  endtask

  function automatic logic [7:0] set_a(int k); return 8'(k * 36 + 3); endfunction
  function automatic logic [7:0] set_b(int k); return 8'(255 - k); endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset leaves nothing valid, no response pending
    chk(!resp_valid && !resp_hit && !resp_tlb_miss, "R8 reset outputs",
        {29'd0, resp_valid, resp_hit, resp_tlb_miss}, 32'd0);
    rst_n = 1'b1;
    expect_miss("R8 empty after reset", {vpn_k(0), 8'd3, 4'h0}, 1'b1);
    // R1: no request, no response
    @(negedge clk);
    chk(!resp_valid, "R1 idle after response", {31'd0, resp_valid}, 32'd0);

    for (int k = 0; k < 7; k++) fill_tlb(vpn_k(k), ppn_k(k));
    fill_tlb(20'h00200, ppn_k(0));  // alias of entry 0, lands in entry 7
    for (int k = 0; k < 7; k++) begin
      fill_line(ppn_k(k), set_a(k));
      fill_line(ppn_k(k), set_b(k));
    end

    // R3 R4: sweep sets, words and byte offsets
    for (int k = 0; k < 7; k++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 4; w++)
          for (int b = 0; b < 4; b += 3) begin
            logic [7:0] ix;
            ix = (s == 0) ? set_a(k) : set_b(k);
            expect_hit("R4 word select", {vpn_k(k), ix, 2'(w), 2'(b)}, word_of(ppn_k(k), ix, w));
          end

    // R9: alias page hits the same line
    for (int w = 0; w < 4; w++)
      expect_hit("R9 alias", {20'h00200, set_a(0), 2'(w), 2'b00}, word_of(ppn_k(0), set_a(0), w));

    // R3: valid translation, wrong physical tag
    expect_miss("R3 tag mismatch", {vpn_k(1), set_a(0), 4'h0}, 1'b0);
    // R2: unknown page
    expect_miss("R2 no translation", {20'h00300, set_a(2), 4'h4}, 1'b1);
    // R5: tag zero equals empty translation result
    fill_line(20'h00000, 8'd5);
    expect_miss("R5 tlb miss masks tag", {20'h00300, 8'd5, 4'h0}, 1'b1);

    // R6 R7: hit makes way 1 the victim
    fill_line(ppn_k(0), 8'd100);
    fill_line(ppn_k(1), 8'd100);
    expect_hit("R7 touch", {vpn_k(0), 8'd100, 4'h8}, word_of(ppn_k(0), 8'd100, 2));
    fill_line(ppn_k(2), 8'd100);
    expect_miss("R6 victim after hit", {vpn_k(1), 8'd100, 4'h0}, 1'b0);
    expect_hit("R6 survivor", {vpn_k(0), 8'd100, 4'h0}, word_of(ppn_k(0), 8'd100, 0));
    expect_hit("R6 new line", {vpn_k(2), 8'd100, 4'hC}, word_of(ppn_k(2), 8'd100, 3));
    // R6 R7: without a hit the older fill is replaced
    fill_line(ppn_k(0), 8'd101);
    fill_line(ppn_k(1), 8'd101);
    fill_line(ppn_k(2), 8'd101);
    expect_miss("R7 oldest evicted", {vpn_k(0), 8'd101, 4'h0}, 1'b0);
    expect_hit("R7 second kept", {vpn_k(1), 8'd101, 4'h4}, word_of(ppn_k(1), 8'd101, 1));
    expect_hit("R6 third placed", {vpn_k(2), 8'd101, 4'h0}, word_of(ppn_k(2), 8'd101, 0));

    // R8: ninth refill wraps onto entry 0
    fill_tlb(20'h00400, ppn_k(3));
    expect_miss("R8 wrap evicts entry 0", {vpn_k(0), set_a(0), 4'h0}, 1'b1);
    expect_hit("R8 wrapped entry", {20'h00400, set_a(3), 4'h4}, word_of(ppn_k(3), set_a(3), 1));
    expect_hit("R8 entry 1 kept", {vpn_k(1), set_a(1), 4'h0}, word_of(ppn_k(1), set_a(1), 0));
    expect_hit("R9 alias outlives entry 0", {20'h00200, set_b(0), 4'h0}, word_of(ppn_k(0), set_b(0), 0));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule